// File: doc/BRIEF.md
# Configurable Width Read Data Multiplexer

This block sits in the read path of a memory device, between the 256-bit internal core bus and the read data bus that is later serialised onto the data pins. The core bus is organised as 16 sets of 16 bits. The read bus is organised as 16 pins, each carrying 16 time slots of one read packet. A width register field, written through a one-cycle configuration strobe, sets how many pins carry data. At full width every core set drives its own pin. At a narrower width only the lowest pins are active. A sub-column value that arrives with each column request then picks which group of core sets those pins carry.

Each request is sampled on a valid strobe. The routed data, a mask of active pins and a valid flag are registered and appear one clock later. Inactive pins are driven to zero.

Top module: `rd_width_mux`

## Requirements
- R1: After reset `q_o` is all zero, `q_oe_o` is all zero, `q_valid_o` is low, and the width register holds the full-width code 3'b000.
- R2: A request sampled with `req_valid_i` high at one rising edge gives `q_valid_o` high after that edge. A rising edge with `req_valid_i` low gives `q_valid_o` low after it.
- R3: At full width (code 3'b000), pin p slot t of the output equals core set p bit t, for every p and t. All 16 bits of `q_oe_o` are set, and the sub-column value has no effect.
- R4: Width codes are 3'b000 for x16, 3'b001 for x8, 3'b010 for x4, 3'b011 for x2 and 3'b100 for x1. A code is stored when `cfg_wr_i` is high at a rising edge, and it applies to requests sampled at later edges.
- R5: At width N (N below 16), let base be the sub-column value with its low log2(N) bits cleared. Pin p, for p below N, carries core set base+p. `q_oe_o` has exactly bits 0 through N-1 set.
- R6: In x4 mode, sub-column bits [1:0] have no effect, and bits [3:2] select one 64-bit block of the core bus.
- R7: Every pin whose `q_oe_o` bit is clear outputs zero in all 16 slots.
- R8: The codes 3'b101, 3'b110 and 3'b111 are stored but route exactly as x16.
- R9: When no request is sampled, `q_o` and `q_oe_o` keep the values they held before that edge.
- R10: If a configuration write and a request are sampled at the same edge, the request uses the width that was stored before the write.
- R11: The output is packed as `q_o[pin*16 + slot]`, and the core input is packed as `core_i[set*16 + bit]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Write strobe for the width register |
| cfg_width_i | input | 3 | Width code to store |
| req_valid_i | input | 1 | Column request strobe |
| req_sc_i | input | 4 | Sub-column value of the request |
| core_i | input | 256 | Core bus, set*16+bit |
| q_o | output | 256 | Read data bus, pin*16+slot |
| q_oe_o | output | 16 | Active pin mask |
| q_valid_o | output | 1 | Read data valid |

## Verification
Every result lands exactly one rising edge after its request: the routed data, the pin mask and the valid flag. A width write changes routing only for requests sampled at a later edge than the write. The bench drives its stimulus on the falling edge. It compares all three outputs 1 ns after the next rising edge against a reference built from the stored width code, the sub-column value and the core bus. For idle edges the bench checks, at the same offset, that valid is low and that data and mask are unchanged. For the same-edge write case it expects the old width, and it checks the new width only on the following request.

// File: rtl/rd_width_pkg.sv
package rd_width_pkg;
    typedef enum logic [2:0] {
        WCODE_X16 = 3'b000,
        WCODE_X8  = 3'b001,
        WCODE_X4  = 3'b010,
        WCODE_X2  = 3'b011,
        WCODE_X1  = 3'b100
    } wcode_e;
endpackage

// File: rtl/rd_width_decode.sv
module rd_width_decode #(
    parameter int PINS   = 16,
    parameter int CODE_W = 3,
    localparam int LOG_PINS = $clog2(PINS),
    localparam int LGW      = $clog2(LOG_PINS + 1)
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [LGW-1:0]    lg_n_o,
    output logic [PINS-1:0]   oe_o
);
    // reserved codes fall back to full width
    always_comb begin
        if (code_i > CODE_W'(LOG_PINS)) begin
            lg_n_o = LGW'(LOG_PINS);
        end else begin
            lg_n_o = LGW'(LOG_PINS) - LGW'(code_i);
        end
    end

    for (genvar p = 0; p < PINS; p++) begin : g_oe
        logic [LOG_PINS:0] n_act;
        always_comb begin
            n_act   = (LOG_PINS+1)'(1) << lg_n_o;
            oe_o[p] = (LOG_PINS+1)'(p) < n_act;
        end
    end
endmodule

// File: rtl/rd_slice_mux.sv
module rd_slice_mux #(
    parameter int PINS  = 16,
    parameter int SLOTS = 16,
    localparam int LOG_PINS = $clog2(PINS),
    localparam int LGW      = $clog2(LOG_PINS + 1),
    localparam int BUS_W    = PINS * SLOTS
) (
    input  logic [BUS_W-1:0]    core_i,
    input  logic [LOG_PINS-1:0] sc_i,
    input  logic [LGW-1:0]      lg_n_i,
    input  logic [PINS-1:0]     oe_i,
    output logic [BUS_W-1:0]    q_o
);
    logic [LOG_PINS:0]   one_hot;
    logic [LOG_PINS:0]   low_full;
    logic [LOG_PINS-1:0] base;

    // group base: sub-column value with its low log2(N) bits cleared
    always_comb begin
        one_hot  = (LOG_PINS+1)'(1) << lg_n_i;
        low_full = one_hot - (LOG_PINS+1)'(1);
        base     = sc_i & ~low_full[LOG_PINS-1:0];
    end

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic [LOG_PINS-1:0] src;
        always_comb begin
            src = base | LOG_PINS'(p);
            if (oe_i[p]) begin
                q_o[p*SLOTS +: SLOTS] = core_i[src*SLOTS +: SLOTS];
            end else begin
                q_o[p*SLOTS +: SLOTS] = '0;
            end
        end
    end
endmodule

// File: rtl/rd_width_mux.sv
module rd_width_mux #(
    parameter int PINS   = 16,
    parameter int SLOTS  = 16,
    parameter int CODE_W = 3,
    localparam int LOG_PINS = $clog2(PINS),
    localparam int LGW      = $clog2(LOG_PINS + 1),
    localparam int BUS_W    = PINS * SLOTS
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                cfg_wr_i,
    input  logic [CODE_W-1:0]   cfg_width_i,
    input  logic                req_valid_i,
    input  logic [LOG_PINS-1:0] req_sc_i,
    input  logic [BUS_W-1:0]    core_i,
    output logic [BUS_W-1:0]    q_o,
    output logic [PINS-1:0]     q_oe_o,
    output logic                q_valid_o
);
    import rd_width_pkg::*;

    typedef struct packed {
        logic [CODE_W-1:0] width;
        logic [BUS_W-1:0]  q;
        logic [PINS-1:0]   oe;
        logic              valid;
    } state_t;

    state_t state_d, state_q;

    logic [LGW-1:0]   lg_n;
    logic [PINS-1:0]  oe_sel;
    logic [BUS_W-1:0] q_sel;

    // routing uses the stored width, so a same-edge write affects later requests only
    rd_width_decode #(.PINS(PINS), .CODE_W(CODE_W)) u_dec (
        .code_i (state_q.width),
        .lg_n_o (lg_n),
        .oe_o   (oe_sel)
    );

    rd_slice_mux #(.PINS(PINS), .SLOTS(SLOTS)) u_mux (
        .core_i (core_i),
        .sc_i   (req_sc_i),
        .lg_n_i (lg_n),
        .oe_i   (oe_sel),
        .q_o    (q_sel)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = req_valid_i;
        if (cfg_wr_i) begin
            state_d.width = cfg_width_i;
        end
        if (req_valid_i) begin
            state_d.q  = q_sel;
            state_d.oe = oe_sel;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q       <= '0;
            state_q.width <= CODE_W'(WCODE_X16);
        end else begin
            state_q <= state_d;
        end
    end

    assign q_o       = state_q.q;
    assign q_oe_o    = state_q.oe;
    assign q_valid_o = state_q.valid;
endmodule

// File: rtl/rd_width_mux_chk.sv
module rd_width_mux_chk #(
    parameter int PINS   = 16,
    parameter int SLOTS  = 16,
    parameter int CODE_W = 3,
    localparam int LOG_PINS = $clog2(PINS),
    localparam int BUS_W    = PINS * SLOTS
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                cfg_wr_i,
    input logic [CODE_W-1:0]   cfg_width_i,
    input logic                req_valid_i,
    input logic [LOG_PINS-1:0] req_sc_i,
    input logic [BUS_W-1:0]    core_i,
    input logic [BUS_W-1:0]    q_o,
    input logic [PINS-1:0]     q_oe_o,
    input logic                q_valid_o
);
    // checker-side copy of the width code, built from the write port
    logic [CODE_W-1:0] seen_w;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       seen_w <= '0;
        else if (cfg_wr_i) seen_w <= cfg_width_i;
    end

    a_r2_valid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> q_valid_o);

    a_r2_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !q_valid_o);

    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> ($stable(q_o) && $stable(q_oe_o)));

    a_r5_oe_low_contig: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q_valid_o |-> (q_oe_o[0] && ((q_oe_o & (q_oe_o + 1'b1)) == '0)));

    a_r3_full_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && seen_w == '0) |=> (q_o == $past(core_i) && q_oe_o == '1));

    a_r8_reserved_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && seen_w > CODE_W'(LOG_PINS)) |=> (q_o == $past(core_i)));

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        a_r7_idle_pin_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !q_oe_o[p] |-> (q_o[p*SLOTS +: SLOTS] == '0));
    end
endmodule

bind rd_width_mux rd_width_mux_chk #(.PINS(PINS), .SLOTS(SLOTS), .CODE_W(CODE_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_width_i (cfg_width_i),
    .req_valid_i (req_valid_i),
    .req_sc_i    (req_sc_i),
    .core_i      (core_i),
    .q_o         (q_o),
    .q_oe_o      (q_oe_o),
    .q_valid_o   (q_valid_o)
);

// File: tb/sim_rd_width_mux.sv
`timescale 1ns/1ps
module sim_rd_width_mux;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [2:0]   cfg_w = '0;
    logic         req = 1'b0;
    logic [3:0]   sc = '0;
    logic [255:0] core = '0;
    logic [255:0] q;
    logic [15:0]  oe;
    logic         qv;

    int checks = 0;
    int errors = 0;
    logic [2:0]   mw = 3'b000;
    logic [255:0] last_q;

    always #2 clk = ~clk;

    rd_width_mux u0 (
        .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_width_i(cfg_w),
        .req_valid_i(req), .req_sc_i(sc), .core_i(core),
        .q_o(q), .q_oe_o(oe), .q_valid_o(qv)
    );

    function automatic int act_pins(logic [2:0] w);
        return (w > 3'd4) ? 16 : (16 >> w);
    endfunction

    function automatic logic [255:0] ref_q(logic [2:0] w, logic [3:0] s, logic [255:0] c);
        logic [255:0] r = '0;
        int n = act_pins(w);
        int grp = (s / n) * n;
        for (int p = 0; p < n; p++) r[p*16 +: 16] = c[(grp + p)*16 +: 16];
        return r;
    endfunction

    function automatic logic [15:0] ref_oe(logic [2:0] w);
        logic [15:0] m = '0;
        for (int p = 0; p < act_pins(w); p++) m[p] = 1'b1;
        return m;
    endfunction

    function automatic logic [255:0] rnd_core();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(string tag, logic [255:0] got, logic [255:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic set_width(logic [2:0] w);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_w = w;
        @(negedge clk);
        cfg_wr = 1'b0;
        mw = w;
    endtask

    task automatic do_req(string tag, logic [3:0] s, logic [255:0] c);
        @(negedge clk);
        req = 1'b1; sc = s; core = c;
        @(posedge clk); #1;
        chk({tag, " valid"}, 256'(qv), 256'(1));
        chk({tag, " data"}, q, ref_q(mw, s, c));
        chk({tag, " oe"}, 256'(oe), 256'(ref_oe(mw)));
        last_q = q;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [255:0] c0;
        logic [255:0] q_a;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 q", q, '0);
        chk("R1 oe", 256'(oe), '0);
        chk("R1 valid", 256'(qv), '0);
        @(negedge clk); rst_n = 1'b1;

        // R3 default full width, R11 packing with a pin-numbered pattern
        c0 = '0;
        for (int p = 0; p < 16; p++) c0[p*16 +: 16] = 16'(p * 16'h1111 + 16'h0a00);
        do_req("R3 R11 default", 4'hb, c0);
        chk("R3 pin5 packing", 256'(q[5*16 +: 16]), 256'(c0[5*16 +: 16]));

        // R9 / R2 idle edge: valid low and outputs held
        @(posedge clk); #1;
        chk("R2 idle valid", 256'(qv), '0);
        chk("R9 hold data", q, last_q);

        // R4 R5 each narrow width, every sub-column value
        for (int w = 1; w <= 4; w++) begin
            set_width(3'(w));
            for (int s = 0; s < 16; s++) do_req("R4 R5 R7 narrow", 4'(s), rnd_core());
        end

        // R6 x4 ignores SC[1:0]
        set_width(3'b010);
        c0 = rnd_core();
        do_req("R6 sc8", 4'b1000, c0);
        q_a = q;
        do_req("R6 sc11", 4'b1011, c0);
        chk("R6 low sc ignored", q, q_a);
        chk("R6 block two", 256'(q[63:0]), 256'(c0[191:128]));

        // R8 reserved codes
        for (int w = 5; w <= 7; w++) begin
            set_width(3'(w));
            do_req("R8 reserved", 4'(w), rnd_core());
        end

        // R10 write and request at one edge: request uses old width
        set_width(3'b000);
        c0 = rnd_core();
        @(negedge clk);
        cfg_wr = 1'b1; cfg_w = 3'b100; req = 1'b1; sc = 4'h7; core = c0;
        @(posedge clk); #1;
        chk("R10 old width data", q, ref_q(3'b000, 4'h7, c0));
        chk("R10 old width oe", 256'(oe), 256'(16'hffff));
        @(negedge clk);
        cfg_wr = 1'b0; req = 1'b0; mw = 3'b100;
        do_req("R10 new width", 4'h7, c0);

        // random mix
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 3) == 0) set_width(3'($urandom_range(0, 7)));
            do_req("R5 R8 random", 4'($urandom_range(0, 15)), rnd_core());
            if ($urandom_range(0, 1) == 0) begin
                @(posedge clk); #1;
                chk("R9 random hold", q, last_q);
                chk("R2 random idle", 256'(qv), '0);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule